// File: doc/BRIEF.md
# Trimmed-Mean Sample Averaging Filter

This block averages a burst of 12-bit unsigned converter samples taken on one channel. It drops the single smallest and the single largest sample of the burst and returns the mean of the rest. Samples are straight binary: 000h stands for 0 V and FFFh for full scale. The block keeps only a running sum, a running minimum, a running maximum and a sample count, so it needs no sorting storage.

A burst holds 6 or 10 samples, chosen by a count-select input. Because the two extreme samples are removed, 4 or 8 samples remain, and the division becomes a right shift by 2 or 3. A clear pulse throws away a partial burst. After each result the block starts the next burst on its own, so a channel sequencer can stream bursts without any gap between them.

Top module: `trimmed_mean_filter`

## Requirements
- R1: After reset, `res_vld_o` is 0 and `res_o` is 000h.
- R2: A burst is 6 accepted samples when `cnt_sel_i` is 0 and 10 when it is 1. `cnt_sel_i` is captured with the first sample of a burst, and later changes have no effect on that burst.
- R3: The result is (sum − min − max) shifted right by 2 for a 6-sample burst or by 3 for a 10-sample burst. The shift truncates, and the result is 12-bit unsigned.
- R4: When several samples share the minimum or the maximum value, only one instance of each is removed.
- R5: Ten full-scale samples (FFFh) give FFFh, so the accumulator does not overflow.
- R6: `res_vld_o` is high for exactly one cycle: the cycle after the last sample of the burst is accepted. `res_o` holds its value until the next result.
- R7: A `clr_i` pulse discards the partial burst. A sample presented in the same cycle as `clr_i` is dropped.
- R8: After a result, accumulation restarts by itself. A sample in the cycle where `res_vld_o` is high is the first sample of the new burst.
- R9: Data presented while `smp_vld_i` is 0 has no effect on the burst or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Discards the partial burst and restarts accumulation |
| cnt_sel_i | input | 1 | Burst length select: 0 gives 6 samples, 1 gives 10 |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 12 | Sample value, unsigned |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_o | output | 12 | Trimmed mean |

## Verification
The result is registered at the clock edge that accepts the last sample of a burst. Both `res_vld_o` and `res_o` are therefore due in the cycle after that sample is presented, and they drop back one cycle later. The bench drives each sample on a falling edge. After the last sample it waits exactly one falling edge and then compares the output with the value computed from that burst. After every sample that is not the last, it checks that no strobe has appeared early. Clear and select changes are applied between falling edges, so their effect appears at the next result or the next sampled strobe.

// File: rtl/trimmed_mean_filter.sv
module trimmed_mean_filter #(
  parameter int DW        = 12,
  parameter int AW        = 16,
  parameter int SHORT_LEN = 6,
  parameter int LONG_LEN  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cnt_sel_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] smp_i,
  output logic          res_vld_o,
  output logic [DW-1:0] res_o
);
  localparam int CW     = $clog2(LONG_LEN + 1);
  localparam int SSH    = $clog2(SHORT_LEN - 2);
  localparam int LSH    = $clog2(LONG_LEN - 2);
  localparam int PAD    = AW - DW;
  localparam logic [CW-1:0] SLAST = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] LLAST = CW'(LONG_LEN - 1);

  logic [AW-1:0] sum_q, sum_n, trim, shifted;
  logic [DW-1:0] min_q, max_q, min_n, max_n, res_q;
  logic [CW-1:0] cnt_q;
  logic          sel_q, vld_q, sel_eff, take, last;

  assign sel_eff = (cnt_q == '0) ? cnt_sel_i : sel_q;
  assign take    = smp_vld_i & ~clr_i;
  assign last    = take & (cnt_q == (sel_eff ? LLAST : SLAST));

  assign sum_n   = sum_q + {{PAD{1'b0}}, smp_i};
  assign min_n   = (smp_i < min_q) ? smp_i : min_q;
  assign max_n   = (smp_i > max_q) ? smp_i : max_q;
  assign trim    = sum_n - {{PAD{1'b0}}, min_n} - {{PAD{1'b0}}, max_n};
  assign shifted = sel_eff ? (trim >> LSH) : (trim >> SSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      min_q <= '1;
      max_q <= '0;
      cnt_q <= '0;
      sel_q <= 1'b0;
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= last;
      if (last) res_q <= shifted[DW-1:0];
      if (clr_i || last) begin
        sum_q <= '0;
        min_q <= '1;
        max_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sum_q <= sum_n;
        min_q <= min_n;
        max_q <= max_n;
        cnt_q <= cnt_q + 1'b1;
        sel_q <= sel_eff;
      end
    end
  end

  assign res_vld_o = vld_q;
  assign res_o     = res_q;
endmodule

// File: rtl/trimmed_mean_filter_chk.sv
module trimmed_mean_filter_chk #(
  parameter int DW        = 12,
  parameter int SHORT_LEN = 6,
  parameter int LONG_LEN  = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          smp_vld_i,
  input logic          res_vld_o,
  input logic [DW-1:0] res_o
);
  logic [7:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= '0;
    else if (clr_i)      seen_q <= '0;
    else if (res_vld_o)  seen_q <= smp_vld_i ? 8'd1 : 8'd0;
    else if (smp_vld_i)  seen_q <= seen_q + 8'd1;
  end

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> $stable(res_o));

  // R7
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !res_vld_o);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (seen_q == 8'(SHORT_LEN) || seen_q == 8'(LONG_LEN)));

  // R9
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_vld_o) |-> $past(smp_vld_i));
endmodule

bind trimmed_mean_filter trimmed_mean_filter_chk #(
  .DW(DW), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .smp_vld_i(smp_vld_i),
  .res_vld_o(res_vld_o), .res_o(res_o)
);

// File: tb/test_trimmed_mean_filter.sv
`timescale 1ns/1ps
module test_trimmed_mean_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        cnt_sel_i = 1'b0;
  logic        smp_vld_i = 1'b0;
  logic [11:0] smp_i = '0;
  logic        res_vld_o;
  logic [11:0] res_o;

  int checks = 0;
  int errors = 0;
  int smp_buf[10];

  always #2.5 clk = ~clk;

  trimmed_mean_filter i_trimmed_mean_filter (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cnt_sel_i(cnt_sel_i),
    .smp_vld_i(smp_vld_i), .smp_i(smp_i), .res_vld_o(res_vld_o), .res_o(res_o)
  );

  function automatic int ref_mean(input int n);
    int s = 0, mn = 4095, mx = 0;
    for (int i = 0; i < n; i++) begin
      s += smp_buf[i];
      if (smp_buf[i] < mn) mn = smp_buf[i];
      if (smp_buf[i] > mx) mx = smp_buf[i];
    end
    return (s - mn - mx) >> ((n == 10) ? 3 : 2);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int s);
    smp_vld_i = 1'b1;
    smp_i = 12'(s);
    @(negedge clk);
    smp_vld_i = 1'b0;
    smp_i = 12'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      smp_i = 12'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic burst(input int n, input bit gaps, input string req);
    int exp = ref_mean(n);
    cnt_sel_i = (n == 10);
    for (int i = 0; i < n; i++) begin
      if (gaps) idle($urandom_range(0, 3));
      put(smp_buf[i]);
      if (i < n - 1 && res_vld_o) check({req, " early strobe"}, 1, 0);
    end
    check({req, " strobe"}, int'(res_vld_o), 1);
    check({req, " value"}, int'(res_o), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    check("R1 vld", int'(res_vld_o), 0);
    check("R1 res", int'(res_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 basic short burst with truncation: (5)>>2 = 1
    smp_buf[0:5] = '{0, 1, 1, 1, 2, 4095};
    burst(6, 0, "R3 trunc");
    // R6 one-cycle pulse and hold
    @(negedge clk);
    check("R6 pulse", int'(res_vld_o), 0);
    check("R6 hold", int'(res_o), 1);

    // R4 duplicated extremes: (38-1-9)>>2 = 7
    smp_buf[0:5] = '{1, 9, 1, 9, 9, 9};
    burst(6, 0, "R4 dup");

    // R5 full scale, long burst
    for (int i = 0; i < 10; i++) smp_buf[i] = 4095;
    burst(10, 0, "R5 full");
    for (int i = 0; i < 10; i++) smp_buf[i] = 0;
    burst(10, 0, "R3 zero");

    // R2 select change after the first sample is ignored
    smp_buf[0:5] = '{100, 200, 300, 400, 500, 600};
    cnt_sel_i = 1'b0;
    put(100); cnt_sel_i = 1'b1;
    for (int i = 1; i < 6; i++) put(smp_buf[i]);
    check("R2 latch strobe", int'(res_vld_o), 1);
    check("R2 latch value", int'(res_o), ref_mean(6));
    cnt_sel_i = 1'b0;

    // R7 clear discards partial burst
    put(4000); put(4000); put(4000);
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    check("R7 no strobe", int'(res_vld_o), 0);
    smp_buf[0:5] = '{10, 20, 30, 40, 50, 60};
    burst(6, 0, "R7 after clear");

    // R7 sample together with clear is dropped
    clr_i = 1'b1; put(4095); clr_i = 1'b0;
    smp_buf[0:5] = '{7, 7, 7, 7, 7, 8};
    burst(6, 0, "R7 same cycle");

    // R8 back-to-back bursts, first sample while strobe high
    smp_buf[0:5] = '{50, 60, 70, 80, 90, 99};
    burst(6, 0, "R8 first");
    smp_buf[0:5] = '{1000, 1100, 1200, 1300, 1400, 1500};
    burst(6, 0, "R8 second");

    // R9 random bursts with idle gaps carrying junk data
    for (int b = 0; b < 40; b++) begin
      int n = ($urandom_range(0, 1) == 1) ? 10 : 6;
      for (int i = 0; i < n; i++) smp_buf[i] = $urandom_range(0, 4095);
      burst(n, 1, (n == 10) ? "R9 R2 random long" : "R9 R3 random short");
    end

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule